// File: doc/BRIEF.md
# Match Timer with Output Actions and PWM

This block is a free-running or event-driven up-counter with a prescaler and four compare channels. Each channel compares its value with the counter and, when they meet, can reload the counter, halt it, post an interrupt flag and change a per-channel output bit. The counter advances on every clock or on edges of one chosen input pin. Three channels can also act as pulse-width outputs, with the last channel setting the common period.

Software reaches it through a plain register port. A write is a single-cycle strobe with address and data, and it takes effect at that clock edge. A read is a combinational lookup of `rd_addr`. There is no streaming data path, so no valid/ready handshake is used. The address map is CTRL 0, MODE 1, PRESCALE 2, MATCH_CTRL 3, OUT_CTRL 4, OUT_STATE 5, PWM 6, FLAGS 7, MATCH0..MATCH3 at 8..11 and COUNT (read-only) at 12.

Top module: `match_timer`

## Requirements
- R1: After reset, CTRL, PRESCALE, MATCH_CTRL, OUT_CTRL, PWM, FLAGS and COUNT read 0. Every MATCH register reads all ones. `match_out` and `irq` are 0.
- R2: When MODE[1:0]=0 and the enable bit (CTRL bit 0) is set, COUNT rises by one on each clock. When the enable bit is cleared, COUNT holds its value.
- R3: While the counter-reset bit (CTRL bit 1) is set, COUNT and the prescale counter are cleared at each clock edge. This overrides counting.
- R4: With PRESCALE = P, COUNT advances once per P+1 qualifying events. P = 0 advances it on every event.
- R5: MODE[3:2] selects an input pin, which is synchronised. MODE[1:0]=1 counts its rising edges, 2 its falling edges and 3 both edges. A counted edge shows in COUNT three clocks after the pin changes. Pins that are not selected have no effect.
- R6: Channel i fires on the count step where COUNT takes the value MATCH i. If its reset bit (MATCH_CTRL bit 3i+1) is set, the next count step loads 0 instead of MATCH i + 1.
- R7: If the stop bit of channel i (MATCH_CTRL bit 3i+2) is set, the enable bit clears at the edge where the channel fires. COUNT then holds at MATCH i. The stop wins over a same-cycle write of CTRL.
- R8: If the interrupt bit of channel i (MATCH_CTRL bit 3i) is set, a firing sets FLAGS bit i. `irq` is the OR of FLAGS. Writing FLAGS clears the bits written as 1. A firing in the same cycle as such a clear leaves the bit set.
- R9: OUT_CTRL bits [2i+1:2i] choose the output action of channel i on firing: 0 none, 1 clear, 2 set, 3 toggle. Writing OUT_STATE loads all output bits from its low bits.
- R10: PWM bit i (i = 0..2) puts `match_out[i]` in pulse mode: low while COUNT < MATCH i, high from MATCH i onward. PWM bit 3 is ignored and reads 0.
- R11: While any PWM bit is set, channel 3 reloads the counter as if its reset bit were set. This gives a period of MATCH3+1 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` |
| cnt_pin | input | 4 | Asynchronous count-source pins |
| match_out | output | 4 | Per-channel output bits |
| irq | output | 1 | OR of the interrupt flags |

## Verification
The hardest case to reach is a clearing write to FLAGS that lands on the same edge where a channel fires. The bench reaches it by reloading the counter and starting it from a known edge. It then counts clocks so that the FLAGS write strobe coincides exactly with the count step onto the match value. Stop-versus-enable timing and the three-clock latency of pin edges are handled the same way. The bench stages every check from the count step it expects the counter to take.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    CNT_CLK  = 2'd0,
    CNT_RISE = 2'd1,
    CNT_FALL = 2'd2,
    CNT_BOTH = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TGL  = 2'd3
  } out_act_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MCTL   = 4'd3;
  localparam logic [ADDR_W-1:0] A_OCTL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_OSTATE = 4'd5;
  localparam logic [ADDR_W-1:0] A_PWM    = 4'd6;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd8;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd12;
endpackage

// File: rtl/mt_count_src.sv
`timescale 1ns/1ps
module mt_count_src
  import mt_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int WIDTH = 32,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  pins,
  input  cnt_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [WIDTH-1:0] prescale,
  input  logic             run,
  input  logic             clr,
  output logic             tick
);
  logic [N_IN-1:0]  sync1_q, sync2_q;
  logic             prev_q;
  logic             cur;
  logic             evt;
  logic [WIDTH-1:0] pc_q;

  assign cur = sync2_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pins;
      sync2_q <= sync1_q;
      prev_q  <= cur;
    end
  end

  always_comb begin
    case (mode)
      CNT_CLK:  evt = 1'b1;
      CNT_RISE: evt = cur & ~prev_q;
      CNT_FALL: evt = ~cur & prev_q;
      default:  evt = cur ^ prev_q;
    endcase
  end

  assign tick = run && evt && (pc_q >= prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (clr)        pc_q <= '0;
    else if (run && evt) pc_q <= tick ? '0 : pc_q + WIDTH'(1);
  end

  // a nonzero prescale never lets two count steps sit back to back
  AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prescale != '0) ##1 (prescale != '0) |-> !tick); // R4
endmodule

// File: rtl/mt_match_bank.sv
`timescale 1ns/1ps
module mt_match_bank
  import mt_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int N_MATCH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick,
  input  logic [WIDTH-1:0]                tc,
  input  logic [N_MATCH-1:0][WIDTH-1:0]   mval,
  input  logic [N_MATCH-1:0]              rst_en,
  input  logic [N_MATCH-1:0]              stop_en,
  input  logic [N_MATCH-1:0]              int_en,
  input  logic [2*N_MATCH-1:0]            act_bits,
  input  logic [N_MATCH-1:0]              pwm_en,
  input  logic                            ost_wr,
  input  logic [N_MATCH-1:0]              ost_data,
  output logic [WIDTH-1:0]                tc_next,
  output logic [N_MATCH-1:0]              hit_int,
  output logic                            stop_req,
  output logic [N_MATCH-1:0]              match_out
);
  localparam logic [N_MATCH-1:0] PERIOD_CH = N_MATCH'(1) << (N_MATCH-1);

  logic [N_MATCH-1:0] eq, hit, rst_eff, ext_q;
  logic               reset_req;

  assign rst_eff   = rst_en | ((|pwm_en) ? PERIOD_CH : '0);
  assign reset_req = |(rst_eff & eq);
  assign tc_next   = reset_req ? '0 : tc + WIDTH'(1);
  assign hit_int   = hit & int_en;
  assign stop_req  = |(hit & stop_en);

  for (genvar i = 0; i < N_MATCH; i++) begin : g_ch
    out_act_e act;
    assign act = out_act_e'(act_bits[2*i +: 2]);
    assign eq[i]  = (tc == mval[i]);
    assign hit[i] = tick && (tc_next == mval[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ext_q[i] <= 1'b0;
      else if (ost_wr)  ext_q[i] <= ost_data[i];
      else if (hit[i]) begin
        case (act)
          ACT_CLR: ext_q[i] <= 1'b0;
          ACT_SET: ext_q[i] <= 1'b1;
          ACT_TGL: ext_q[i] <= ~ext_q[i];
          default: ext_q[i] <= ext_q[i];
        endcase
      end
    end

    assign match_out[i] = pwm_en[i] ? (tc >= mval[i]) : ext_q[i];

    // output bit only moves on a firing or a direct load
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[i] && !ost_wr) |=> $stable(ext_q[i])); // R9
  end
endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
  import mt_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int N_MATCH = 4,
  parameter int N_IN    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WIDTH-1:0]   rd_data,
  input  logic [N_IN-1:0]    cnt_pin,
  output logic [N_MATCH-1:0] match_out,
  output logic               irq
);
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int MC_W  = 3 * N_MATCH;
  localparam int OC_W  = 2 * N_MATCH;

  logic                          en_q, crst_q;
  cnt_mode_e                     mode_q;
  logic [SEL_W-1:0]              sel_q;
  logic [WIDTH-1:0]              presc_q, tc_q, tc_next;
  logic [MC_W-1:0]               mctl_q;
  logic [OC_W-1:0]               octl_q;
  logic [N_MATCH-1:0]            pwm_q, flags_q, hit_int, clr_mask;
  logic [N_MATCH-1:0]            rst_en, stop_en, int_en;
  logic [N_MATCH-1:0][WIDTH-1:0] match_q;
  logic                          tick, stop_req, run;

  function automatic logic wsel(input logic [ADDR_W-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  assign run      = en_q & ~crst_q;
  assign clr_mask = wsel(A_FLAGS) ? wr_data[N_MATCH-1:0] : '0;
  assign irq      = |flags_q;

  for (genvar i = 0; i < N_MATCH; i++) begin : g_fields
    assign int_en[i]  = mctl_q[3*i];
    assign rst_en[i]  = mctl_q[3*i+1];
    assign stop_en[i] = mctl_q[3*i+2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     match_q[i] <= '1;
      else if (wsel(A_MATCH0 + ADDR_W'(i)))           match_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      crst_q  <= 1'b0;
      mode_q  <= CNT_CLK;
      sel_q   <= '0;
      presc_q <= '0;
      mctl_q  <= '0;
      octl_q  <= '0;
      pwm_q   <= '0;
      flags_q <= '0;
    end else begin
      if (wsel(A_CTRL)) begin
        en_q   <= wr_data[0];
        crst_q <= wr_data[1];
      end
      if (stop_req) en_q <= 1'b0;
      if (wsel(A_MODE)) begin
        mode_q <= cnt_mode_e'(wr_data[1:0]);
        sel_q  <= wr_data[2 +: SEL_W];
      end
      if (wsel(A_PRESC)) presc_q <= wr_data;
      if (wsel(A_MCTL))  mctl_q  <= wr_data[MC_W-1:0];
      if (wsel(A_OCTL))  octl_q  <= wr_data[OC_W-1:0];
      if (wsel(A_PWM))   pwm_q   <= {1'b0, wr_data[N_MATCH-2:0]};
      flags_q <= (flags_q & ~clr_mask) | hit_int;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tc_q <= '0;
    else if (crst_q) tc_q <= '0;
    else if (tick)   tc_q <= tc_next;
  end

  mt_count_src #(.N_IN(N_IN), .WIDTH(WIDTH)) u_src (
    .clk(clk), .rst_n(rst_n), .pins(cnt_pin), .mode(mode_q), .sel(sel_q),
    .prescale(presc_q), .run(run), .clr(crst_q), .tick(tick)
  );

  mt_match_bank #(.WIDTH(WIDTH), .N_MATCH(N_MATCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tc(tc_q), .mval(match_q),
    .rst_en(rst_en), .stop_en(stop_en), .int_en(int_en), .act_bits(octl_q),
    .pwm_en(pwm_q), .ost_wr(wsel(A_OSTATE)), .ost_data(wr_data[N_MATCH-1:0]),
    .tc_next(tc_next), .hit_int(hit_int), .stop_req(stop_req), .match_out(match_out)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:   rd_data = WIDTH'({crst_q, en_q});
      A_MODE:   rd_data = WIDTH'({sel_q, mode_q});
      A_PRESC:  rd_data = presc_q;
      A_MCTL:   rd_data = WIDTH'(mctl_q);
      A_OCTL:   rd_data = WIDTH'(octl_q);
      A_PWM:    rd_data = WIDTH'(pwm_q);
      A_FLAGS:  rd_data = WIDTH'(flags_q);
      A_COUNT:  rd_data = tc_q;
      default: begin
        for (int i = 0; i < N_MATCH; i++)
          if (rd_addr == A_MATCH0 + ADDR_W'(i)) rd_data = match_q[i];
      end
    endcase
  end

  AST_COUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !crst_q) |=> $stable(tc_q)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) |=> ((flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask))); // R8
  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !en_q); // R7
  AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pwm_q) && tick && tc_q == match_q[N_MATCH-1]) |=> (tc_q == '0)); // R11
endmodule

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;
  import mt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  cnt_pin = '0;
  logic [3:0]  match_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 register read, 1 match_out, 2 irq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  match_timer i_match_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin),
    .match_out(match_out), .irq(irq)
  );

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      logic [31:0] act;
      item_t it;
      wait (sb_q.size() != 0);
      it = sb_q[0];
      case (it.kind)
        0:       act = rd_data;
        1:       act = {28'd0, match_out};
        default: act = {31'd0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
      void'(sb_q.pop_front());
    end
  end

  task automatic push(input int kind, input logic [3:0] addr, input logic [31:0] exp, input string tag);
    item_t it;
    rd_addr = addr;
    #0.2;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [31:0] e, input string t);
    push(0, a, e, t);
  endtask
  task automatic chk_out(input logic [3:0] e, input string t);
    push(1, rd_addr, {28'd0, e}, t);
  endtask
  task automatic chk_irq(input logic e, input string t);
    push(2, rd_addr, {31'd0, e}, t);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_count();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic edge_run(input int mode, input logic [31:0] exp, input string t);
    clear_count();
    wr(A_MODE, 32'(mode) | 32'h4);
    cyc(4);
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < 3; k++) begin
      cnt_pin[1] = 1'b1; cyc(3);
      cnt_pin[1] = 1'b0; cnt_pin[0] = 1'b1; cyc(3);
      cnt_pin[0] = 1'b0;
    end
    cyc(5);
    chk_reg(A_COUNT, exp, t);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk_reg(A_CTRL, 32'h0, "R1 ctrl");
    chk_reg(A_COUNT, 32'h0, "R1 count");
    chk_reg(A_FLAGS, 32'h0, "R1 flags");
    chk_reg(A_MATCH0, 32'hFFFF_FFFF, "R1 match0");
    chk_out(4'h0, "R1 match_out");
    chk_irq(1'b0, "R1 irq");

    // R2 free count on clock, then hold
    wr(A_CTRL, 32'h1);
    cyc(5);
    chk_reg(A_COUNT, 32'd5, "R2 count after 5 clocks");
    wr(A_CTRL, 32'h0);
    cyc(3);
    chk_reg(A_COUNT, 32'd6, "R2 count holds when disabled");

    // R3 counter reset
    clear_count();
    chk_reg(A_COUNT, 32'd0, "R3 reset bit clears count");

    // R4 prescale of 2
    wr(A_PRESC, 32'd2);
    wr(A_CTRL, 32'h1);
    cyc(9);
    chk_reg(A_COUNT, 32'd3, "R4 prescale 2 gives one step per 3 clocks");
    clear_count();
    wr(A_PRESC, 32'd0);

    // R6 R8 R9 reset-on-match, flag, toggle
    wr(A_MATCH0, 32'd4);
    wr(A_MCTL, 32'h3);
    wr(A_OCTL, 32'h3);
    wr(A_OSTATE, 32'h0);
    wr(A_CTRL, 32'h1);
    cyc(4);
    chk_reg(A_COUNT, 32'd4, "R6 count reaches match");
    chk_reg(A_FLAGS, 32'h1, "R8 flag bit0 set");
    chk_out(4'b0001, "R9 toggle to 1");
    chk_irq(1'b1, "R8 irq raised");
    cyc(1);
    chk_reg(A_COUNT, 32'd0, "R6 reload to 0 after match");
    cyc(4);
    chk_out(4'b0000, "R9 toggle back to 0");
    wr(A_CTRL, 32'h0);
    wr(A_FLAGS, 32'h1);
    chk_reg(A_FLAGS, 32'h0, "R8 write one clears");
    chk_irq(1'b0, "R8 irq drops");

    // R8 clear collides with firing
    wr(A_MATCH1, 32'd3);
    wr(A_MCTL, 32'h8);
    wr(A_OCTL, 32'h0);
    clear_count();
    wr(A_CTRL, 32'h1);
    cyc(2);
    wr(A_FLAGS, 32'h2);
    chk_reg(A_FLAGS, 32'h2, "R8 firing beats same-cycle clear");
    wr(A_FLAGS, 32'h2);
    chk_reg(A_FLAGS, 32'h0, "R8 later clear works");
    wr(A_CTRL, 32'h0);

    // R7 stop on match with set action
    wr(A_MATCH2, 32'd3);
    wr(A_MCTL, 32'h100);
    wr(A_OCTL, 32'h20);
    wr(A_OSTATE, 32'h0);
    clear_count();
    wr(A_CTRL, 32'h1);
    cyc(8);
    chk_reg(A_COUNT, 32'd3, "R7 counter halted at match");
    chk_reg(A_CTRL, 32'h0, "R7 enable cleared");
    chk_out(4'b0100, "R9 set action");

    // R9 clear action and OUT_STATE load, no-action channels keep value
    wr(A_MCTL, 32'h0);
    wr(A_OSTATE, 32'hF);
    chk_out(4'b1111, "R9 OUT_STATE load");
    wr(A_OCTL, 32'h4);
    clear_count();
    wr(A_CTRL, 32'h1);
    cyc(3);
    chk_out(4'b1101, "R9 clear action only on channel 1");
    wr(A_CTRL, 32'h0);

    // R5 edge counting on pin 1, pin 0 ignored
    wr(A_MCTL, 32'h0);
    wr(A_OCTL, 32'h0);
    edge_run(1, 32'd3, "R5 rising edges");
    edge_run(2, 32'd3, "R5 falling edges");
    edge_run(3, 32'd6, "R5 both edges");
    wr(A_MODE, 32'h0);

    // R10 R11 PWM on channel 0, period from channel 3
    wr(A_MATCH3, 32'd5);
    wr(A_MATCH0, 32'd2);
    wr(A_PWM, 32'h9);
    chk_reg(A_PWM, 32'h1, "R10 bit 3 ignored");
    clear_count();
    wr(A_CTRL, 32'h1);
    cyc(1);
    chk_out({match_out[3:1], 1'b0}, "R10 low below match");
    cyc(1);
    chk_out({match_out[3:1], 1'b1}, "R10 high at match");
    cyc(4);
    chk_reg(A_COUNT, 32'd0, "R11 wrap at channel 3");
    chk_out({match_out[3:1], 1'b0}, "R10 low after wrap");
    wr(A_CTRL, 32'h0);
    wr(A_PWM, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [3:0] A_MATCH1 = A_MATCH0 + 4'd1;
  localparam logic [3:0] A_MATCH2 = A_MATCH0 + 4'd2;
  localparam logic [3:0] A_MATCH3 = A_MATCH0 + 4'd3;
endmodule